// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line priority resolvers, a master and a slave, whose slave output is wired onto master line 2. It does not arbitrate itself: each resolver reports its current winning line, and the sequencer turns the processor's acknowledge cycles and poll reads into three things. These are an interrupt vector, per-resolver update commands, and a poll result. Each update command either moves a line into service or clears both its request and in-service bits.

Both the acknowledge strobe and the poll strobe are valid/ready inputs. Their results, the vector and the poll response, are valid/ready outputs. A result is held stable while its consumer keeps ready low, and no new request of that kind is accepted until the held result has been taken. Only one request is in flight per path. When both strobes are offered in the same cycle, acknowledge is taken first. The resolver commands, the cascade pulse and the read-select pulse are plain one-cycle outputs.

Top module: `cas_ack_seq`

## Requirements
- R1: One cycle after `s_win_valid` goes from 0 to 1, `cascade_pulse` is high for exactly one cycle. It stays low while `s_win_valid` is held high.
- R2: Case: an acknowledge is accepted while the master winner is valid and is not line 2. The vector is `{m_base, m_win_line}`. The master receives an in-service command (`m_op_clr`=0) for that line. The slave receives no command.
- R3: Case: an acknowledge is accepted while the master winner is line 2 and the slave has a winner. The master receives an in-service command for line 2. The slave receives an in-service command for its line. The vector is `{s_base, s_win_line}`.
- R4: Case: an acknowledge is accepted while the master winner is line 2 and the slave has no winner. The vector is `{s_base, 3'd7}`. Only the master receives a command, which is an in-service command for line 2.
- R5: Case: an acknowledge is accepted with no master winner. The vector is `{m_base, 3'd7}` and no resolver command is issued.
- R6: The vector and the resolver commands appear in the cycle after the acknowledge is accepted. `ack_ready` is low while `vec_valid` is high. The vector holds steady while `vec_ready` is low.
- R7: Master poll (`poll_target` 0 or 3). The response is the master winning line, and a clear command (`m_op_clr`=1) is sent for that line. With no master winner, the response is 7 and no command is sent.
- R8: Slave poll (`poll_target` 1). The response is the slave winning line. The slave receives a clear command for that line and the master receives a clear command for line 2. With no slave winner, the response is 7 and no command is sent.
- R9: Combined poll (`poll_target` 2). The master is polled first as in R7. If that result is 2, the slave is also polled as in R8 and the response is 8 plus the slave result; a spurious slave gives 15. `rsel_isr_set` pulses with every combined poll response.
- R10: When `ack_valid` and `poll_valid` are both high, `poll_ready` is low and only the acknowledge is accepted.
- R11: After reset, `vec_valid`, `poll_rsp_valid`, all command valids, `cascade_pulse` and `rsel_isr_set` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_base | input | 5 | Upper vector bits for master lines |
| s_base | input | 5 | Upper vector bits for slave lines |
| m_win_valid | input | 1 | Master resolver has a winner |
| m_win_line | input | 3 | Master winning line |
| s_win_valid | input | 1 | Slave resolver has a winner |
| s_win_line | input | 3 | Slave winning line |
| ack_valid | input | 1 | Processor acknowledge request |
| ack_ready | output | 1 | Acknowledge can be accepted |
| vec_valid | output | 1 | Vector available |
| vec_ready | input | 1 | Vector consumed |
| vec_data | output | 8 | Interrupt vector |
| poll_valid | input | 1 | Poll read request |
| poll_ready | output | 1 | Poll can be accepted |
| poll_target | input | 2 | 0/3 master, 1 slave, 2 combined |
| poll_rsp_valid | output | 1 | Poll result available |
| poll_rsp_ready | input | 1 | Poll result consumed |
| poll_rsp_data | output | 4 | Poll result |
| m_op_valid | output | 1 | Master command pulse |
| m_op_clr | output | 1 | Master command: 0 move to in-service, 1 clear request and in-service |
| m_op_line | output | 3 | Master command line |
| s_op_valid | output | 1 | Slave command pulse |
| s_op_clr | output | 1 | Slave command kind, same encoding |
| s_op_line | output | 3 | Slave command line |
| cascade_pulse | output | 1 | One-cycle pulse on master line 2 for new slave activity |
| rsel_isr_set | output | 1 | Master read selection switches to in-service |

## Verification
The hardest situations to reach are the two cascade-spurious ones: the master has picked line 2 but the slave has nothing. These are acknowledge with slave line forced to 7, and combined poll returning 15. From the ports they need a master winner of exactly 2 while the slave winner is invalid. The bench reaches them by sweeping every combination of master valid/line and slave valid/line under acknowledge and under every poll target. The expected vector, response and commands are derived arithmetically for each combination. Separate sequences hold `vec_ready` low to stall the vector, offer both strobes at once, and raise and hold `s_win_valid` to check the cascade pulse.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic {
    OP_INSVC = 1'b0,
    OP_CLEAR = 1'b1
  } op_kind_e;

  typedef enum logic [1:0] {
    PT_MASTER   = 2'd0,
    PT_SLAVE    = 2'd1,
    PT_COMBINED = 2'd2,
    PT_MASTER_B = 2'd3
  } poll_tgt_e;
endpackage

// File: rtl/cas_edge_pulse.sv
module cas_edge_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      prev_q  <= level_i;
      pulse_o <= level_i & ~prev_q;
    end
  end

  // R1: line 2 sees a rise then a fall, never a held level
  p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/cas_ack_path.sv
module cas_ack_path #(
  parameter int LINE_W   = 3,
  parameter int BASE_W   = 5,
  parameter int CAS_LINE = 2
) (
  input  logic                     m_valid,
  input  logic [LINE_W-1:0]        m_line,
  input  logic                     s_valid,
  input  logic [LINE_W-1:0]        s_line,
  input  logic [BASE_W-1:0]        m_base,
  input  logic [BASE_W-1:0]        s_base,
  output logic [BASE_W+LINE_W-1:0] vec,
  output logic                     m_go,
  output logic [LINE_W-1:0]        m_go_line,
  output logic                     s_go,
  output logic [LINE_W-1:0]        s_go_line
);
  localparam logic [LINE_W-1:0] SPUR = '1;
  localparam logic [LINE_W-1:0] CAS  = LINE_W'(CAS_LINE);

  always_comb begin
    vec       = {m_base, SPUR};
    m_go      = 1'b0;
    m_go_line = '0;
    s_go      = 1'b0;
    s_go_line = '0;
    if (m_valid) begin
      m_go      = 1'b1;
      m_go_line = m_line;
      if (m_line == CAS) begin
        vec = {s_base, (s_valid ? s_line : SPUR)};
        if (s_valid) begin
          s_go      = 1'b1;
          s_go_line = s_line;
        end
      end else begin
        vec = {m_base, m_line};
      end
    end
  end
endmodule

// File: rtl/cas_poll_path.sv
module cas_poll_path #(
  parameter int LINE_W   = 3,
  parameter int CAS_LINE = 2
) (
  input  cas_pkg::poll_tgt_e  target,
  input  logic                m_valid,
  input  logic [LINE_W-1:0]   m_line,
  input  logic                s_valid,
  input  logic [LINE_W-1:0]   s_line,
  output logic [LINE_W:0]     result,
  output logic                m_clr,
  output logic [LINE_W-1:0]   m_clr_line,
  output logic                s_clr,
  output logic [LINE_W-1:0]   s_clr_line,
  output logic                rsel
);
  import cas_pkg::*;
  localparam logic [LINE_W-1:0] SPUR = '1;
  localparam logic [LINE_W-1:0] CAS  = LINE_W'(CAS_LINE);

  logic [LINE_W-1:0] m_res, s_res;
  assign m_res = m_valid ? m_line : SPUR;
  assign s_res = s_valid ? s_line : SPUR;

  always_comb begin
    result     = {1'b0, m_res};
    m_clr      = 1'b0;
    m_clr_line = '0;
    s_clr      = 1'b0;
    s_clr_line = '0;
    rsel       = 1'b0;
    unique case (target)
      PT_SLAVE: begin
        result = {1'b0, s_res};
        if (s_valid) begin
          s_clr      = 1'b1;
          s_clr_line = s_line;
          m_clr      = 1'b1;
          m_clr_line = CAS;
        end
      end
      PT_COMBINED: begin
        rsel = 1'b1;
        if (m_valid) begin
          m_clr      = 1'b1;
          m_clr_line = m_line;
          if (m_line == CAS) begin
            result = {1'b1, s_res};
            if (s_valid) begin
              s_clr      = 1'b1;
              s_clr_line = s_line;
            end
          end
        end
      end
      default: begin
        if (m_valid) begin
          m_clr      = 1'b1;
          m_clr_line = m_line;
        end
      end
    endcase
  end
endmodule

// File: rtl/cas_ack_seq.sv
module cas_ack_seq #(
  parameter int LINE_W   = 3,
  parameter int BASE_W   = 5,
  parameter int CAS_LINE = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BASE_W-1:0]        m_base,
  input  logic [BASE_W-1:0]        s_base,
  input  logic                     m_win_valid,
  input  logic [LINE_W-1:0]        m_win_line,
  input  logic                     s_win_valid,
  input  logic [LINE_W-1:0]        s_win_line,
  input  logic                     ack_valid,
  output logic                     ack_ready,
  output logic                     vec_valid,
  input  logic                     vec_ready,
  output logic [BASE_W+LINE_W-1:0] vec_data,
  input  logic                     poll_valid,
  output logic                     poll_ready,
  input  logic [1:0]               poll_target,
  output logic                     poll_rsp_valid,
  input  logic                     poll_rsp_ready,
  output logic [LINE_W:0]          poll_rsp_data,
  output logic                     m_op_valid,
  output logic                     m_op_clr,
  output logic [LINE_W-1:0]        m_op_line,
  output logic                     s_op_valid,
  output logic                     s_op_clr,
  output logic [LINE_W-1:0]        s_op_line,
  output logic                     cascade_pulse,
  output logic                     rsel_isr_set
);
  import cas_pkg::*;
  localparam int VEC_W = BASE_W + LINE_W;

  logic              ack_fire, poll_fire;
  logic [VEC_W-1:0]  a_vec;
  logic              a_m_go, a_s_go;
  logic [LINE_W-1:0] a_m_line, a_s_line;
  logic [LINE_W:0]   p_res;
  logic              p_m_clr, p_s_clr, p_rsel;
  logic [LINE_W-1:0] p_m_line, p_s_line;

  assign ack_ready  = !vec_valid;
  assign ack_fire   = ack_valid && ack_ready;
  assign poll_ready = !poll_rsp_valid && !ack_fire;
  assign poll_fire  = poll_valid && poll_ready;

  cas_edge_pulse u_casc (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (s_win_valid),
    .pulse_o (cascade_pulse)
  );

  cas_ack_path #(.LINE_W(LINE_W), .BASE_W(BASE_W), .CAS_LINE(CAS_LINE)) u_ack (
    .m_valid   (m_win_valid),
    .m_line    (m_win_line),
    .s_valid   (s_win_valid),
    .s_line    (s_win_line),
    .m_base    (m_base),
    .s_base    (s_base),
    .vec       (a_vec),
    .m_go      (a_m_go),
    .m_go_line (a_m_line),
    .s_go      (a_s_go),
    .s_go_line (a_s_line)
  );

  cas_poll_path #(.LINE_W(LINE_W), .CAS_LINE(CAS_LINE)) u_poll (
    .target     (poll_tgt_e'(poll_target)),
    .m_valid    (m_win_valid),
    .m_line     (m_win_line),
    .s_valid    (s_win_valid),
    .s_line     (s_win_line),
    .result     (p_res),
    .m_clr      (p_m_clr),
    .m_clr_line (p_m_line),
    .s_clr      (p_s_clr),
    .s_clr_line (p_s_line),
    .rsel       (p_rsel)
  );

  // vector output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else if (ack_fire) begin
      vec_valid <= 1'b1;
      vec_data  <= a_vec;
    end else if (vec_valid && vec_ready) begin
      vec_valid <= 1'b0;
    end
  end

  // poll response register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_rsp_valid <= 1'b0;
      poll_rsp_data  <= '0;
    end else if (poll_fire) begin
      poll_rsp_valid <= 1'b1;
      poll_rsp_data  <= p_res;
    end else if (poll_rsp_valid && poll_rsp_ready) begin
      poll_rsp_valid <= 1'b0;
    end
  end

  // resolver command pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_op_valid   <= 1'b0;
      m_op_clr     <= 1'b0;
      m_op_line    <= '0;
      s_op_valid   <= 1'b0;
      s_op_clr     <= 1'b0;
      s_op_line    <= '0;
      rsel_isr_set <= 1'b0;
    end else begin
      m_op_valid   <= 1'b0;
      m_op_clr     <= 1'b0;
      m_op_line    <= '0;
      s_op_valid   <= 1'b0;
      s_op_clr     <= 1'b0;
      s_op_line    <= '0;
      rsel_isr_set <= 1'b0;
      if (ack_fire) begin
        m_op_valid <= a_m_go;
        m_op_clr   <= OP_INSVC;
        m_op_line  <= a_m_line;
        s_op_valid <= a_s_go;
        s_op_clr   <= OP_INSVC;
        s_op_line  <= a_s_line;
      end else if (poll_fire) begin
        m_op_valid   <= p_m_clr;
        m_op_clr     <= p_m_clr;
        m_op_line    <= p_m_line;
        s_op_valid   <= p_s_clr;
        s_op_clr     <= p_s_clr;
        s_op_line    <= p_s_line;
        rsel_isr_set <= p_rsel;
      end
    end
  end

  // R6: an accepted acknowledge yields a vector on the next cycle
  p_ack_to_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid && ack_ready |=> vec_valid);
  // R6: a stalled vector keeps its value
  p_vec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_data));
  // R6: poll response also held under back-pressure
  p_rsp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rsp_valid && !poll_rsp_ready |=> poll_rsp_valid && $stable(poll_rsp_data));
  // R3: a slave in-service command only accompanies master line 2 in service
  p_slave_ack_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_op_valid && !s_op_clr |-> m_op_valid && !m_op_clr && m_op_line == LINE_W'(CAS_LINE));
  // R10: the two strobes are never taken together
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_valid && ack_ready && poll_valid && poll_ready));
  // R9: read-select switch only comes with a poll response
  p_rsel_with_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsel_isr_set |-> poll_rsp_valid);
endmodule

// File: tb/sim_cas_ack_seq.sv
module sim_cas_ack_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] m_base = 5'h01, s_base = 5'h0E;
  logic       m_win_valid = 0, s_win_valid = 0;
  logic [2:0] m_win_line = 0, s_win_line = 0;
  logic       ack_valid = 0, vec_ready = 1, poll_valid = 0, poll_rsp_ready = 1;
  logic [1:0] poll_target = 0;
  logic       ack_ready, vec_valid, poll_ready, poll_rsp_valid;
  logic [7:0] vec_data;
  logic [3:0] poll_rsp_data;
  logic       m_op_valid, m_op_clr, s_op_valid, s_op_clr, cascade_pulse, rsel_isr_set;
  logic [2:0] m_op_line, s_op_line;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cas_ack_seq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int opk(input logic v, input logic c, input logic [2:0] l);
    return v ? (16 + (c ? 8 : 0) + l) : 0;
  endfunction

  task automatic set_win(input int mv, input int ml, input int sv, input int sl);
    m_win_valid = mv[0]; m_win_line = ml[2:0];
    s_win_valid = sv[0]; s_win_line = sl[2:0];
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 vec_valid", vec_valid, 0);
    chk("R11 rsp_valid", poll_rsp_valid, 0);
    chk("R11 ops", m_op_valid + s_op_valid, 0);
    chk("R11 pulses", cascade_pulse + rsel_isr_set, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // acknowledge sweep: R2 R3 R4 R5
    for (int k = 0; k < 256; k++) begin
      int mv, ml, sv, sl, ev, em, es;
      string rq;
      mv = (k >> 7) & 1; ml = (k >> 4) & 7; sv = (k >> 3) & 1; sl = k & 7;
      set_win(mv, ml, sv, sl);
      em = 0; es = 0;
      if (mv == 0) begin ev = m_base * 8 + 7; rq = "R5"; end
      else if (ml != 2) begin ev = m_base * 8 + ml; em = 16 + ml; rq = "R2"; end
      else if (sv == 1) begin ev = s_base * 8 + sl; em = 18; es = 16 + sl; rq = "R3"; end
      else begin ev = s_base * 8 + 7; em = 18; rq = "R4"; end
      ack_valid = 1;
      @(negedge clk);
      ack_valid = 0;
      chk({rq, " R6 vec_valid"}, vec_valid, 1);
      chk({rq, " vector"}, vec_data, ev);
      chk({rq, " master op"}, opk(m_op_valid, m_op_clr, m_op_line), em);
      chk({rq, " slave op"}, opk(s_op_valid, s_op_clr, s_op_line), es);
      @(negedge clk);
      chk("R6 vec popped", vec_valid, 0);
    end

    // poll sweep: R7 R8 R9
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 256; k++) begin
        int mv, ml, sv, sl, er, em, es, ers;
        string rq;
        mv = (k >> 7) & 1; ml = (k >> 4) & 7; sv = (k >> 3) & 1; sl = k & 7;
        set_win(mv, ml, sv, sl);
        em = 0; es = 0; ers = 0;
        if (t == 1) begin
          rq = "R8";
          er = sv ? sl : 7;
          if (sv == 1) begin es = 24 + sl; em = 26; end
        end else if (t == 2) begin
          rq = "R9"; ers = 1;
          er = mv ? ml : 7;
          if (mv == 1) em = 24 + ml;
          if (mv == 1 && ml == 2) begin
            er = 8 + (sv ? sl : 7);
            if (sv == 1) es = 24 + sl;
          end
        end else begin
          rq = "R7";
          er = mv ? ml : 7;
          if (mv == 1) em = 24 + ml;
        end
        poll_target = t[1:0];
        poll_valid = 1;
        @(negedge clk);
        poll_valid = 0;
        chk({rq, " rsp_valid"}, poll_rsp_valid, 1);
        chk({rq, " result"}, poll_rsp_data, er);
        chk({rq, " master op"}, opk(m_op_valid, m_op_clr, m_op_line), em);
        chk({rq, " slave op"}, opk(s_op_valid, s_op_clr, s_op_line), es);
        chk({rq, " rsel"}, rsel_isr_set, ers);
        @(negedge clk);
      end
    end

    // R6 back-pressure hold
    set_win(1, 5, 0, 0);
    vec_ready = 0;
    ack_valid = 1;
    @(negedge clk);
    ack_valid = 0;
    set_win(1, 3, 0, 0);
    repeat (3) @(negedge clk);
    chk("R6 held valid", vec_valid, 1);
    chk("R6 held data", vec_data, m_base * 8 + 5);
    chk("R6 ack_ready low", ack_ready, 0);
    vec_ready = 1;
    @(negedge clk);
    chk("R6 released", vec_valid, 0);

    // R10 simultaneous strobes
    set_win(1, 4, 0, 0);
    ack_valid = 1; poll_valid = 1; poll_target = 2'd0;
    #0;
    chk("R10 poll_ready", poll_ready, 0);
    @(negedge clk);
    ack_valid = 0; poll_valid = 0;
    chk("R10 vec taken", vec_valid, 1);
    chk("R10 poll not taken", poll_rsp_valid, 0);
    chk("R10 op is in-service", opk(m_op_valid, m_op_clr, m_op_line), 20);
    @(negedge clk);

    // R1 cascade pulse
    set_win(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R1 idle", cascade_pulse, 0);
    s_win_valid = 1;
    @(negedge clk);
    chk("R1 pulse high", cascade_pulse, 1);
    @(negedge clk);
    chk("R1 pulse falls", cascade_pulse, 0);
    @(negedge clk);
    chk("R1 held level no pulse", cascade_pulse, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule